// File: doc/BRIEF.md
# Packed Subword Arithmetic Unit

This block is the SIMD execution stage for a 32-bit integer datapath. It views each source operand as four independent 8-bit lanes or two independent 16-bit lanes. On each lane it performs wrap-around add or subtract, equality or greater-than compare, or a left or right shift. Carries, borrows and shifted bits never cross a lane boundary. A compare writes a full mask into each lane: all ones where the condition holds and all zeros where it does not.

An operation is issued by raising `in_valid` with both operands and the control fields. The result is captured in a register and appears on `res` one clock later, with `res_valid` high for exactly that cycle. The shift count is the 5-bit immediate or the low five bits of the second operand, chosen by a select input.

The output stage is a two-state machine. `OUT_IDLE` means no result was produced on the previous edge. `OUT_LIVE` means `res` holds a result that was issued on the previous edge. There are two transitions. ISSUE moves to `OUT_LIVE` on any edge where `in_valid` is high, and DRAIN moves to `OUT_IDLE` on any edge where it is low. Reset forces `OUT_IDLE`.

Top module: `packed_subword_unit`

## Requirements
- R1: With `lane_half`=0 lane i (i=0..3) is bits [8i+7:8i]; with `lane_half`=1 lane i (i=0..1) is bits [16i+15:16i]; every lane is computed independently.
- R2: Opcode 3'd0 (add) returns (a+b) mod 2^w per lane, with no carry into the neighbouring lane.
- R3: Opcode 3'd1 (subtract) returns (a-b) mod 2^w per lane, with no borrow across lanes; the result is the same for signed and unsigned lanes.
- R4: Opcode 3'd2 (equal compare) writes all ones into a lane whose a and b lanes are equal, all zeros otherwise.
- R5: Opcode 3'd3 (greater compare) writes all ones into a lane where a > b, all zeros otherwise; the compare is two's complement when `is_signed`=1 and unsigned when it is 0.
- R6: Opcode 3'd4 (left shift) shifts each lane left and fills with zeros; a count at or above the lane width gives zero.
- R7: Opcode 3'd5 (right shift) is arithmetic when `is_signed`=1 and logical otherwise; a count at or above the lane width gives the lane's sign fill (arithmetic) or zero (logical).
- R8: The shift count is `src_b[4:0]` when `cnt_from_reg`=1 and `shamt_imm` when it is 0.
- R9: Opcodes 3'd6 and 3'd7 produce a zero result.
- R10: `res` and `res_valid` change only on a clock edge; `res_valid` is high in exactly the cycle after a cycle with `in_valid` high, and `res` then holds that issue's result.
- R11: While `in_valid` is low, `res` keeps its last value and `res_valid` is low in the following cycle.
- R12: A synchronous reset clears `res` to zero and `res_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue strobe |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand; low five bits can give the shift count |
| shamt_imm | input | 5 | Immediate shift count |
| op | input | 3 | Operation code: 0 add, 1 sub, 2 eq, 3 gt, 4 shl, 5 shr |
| lane_half | input | 1 | 0: four byte lanes, 1: two half-word lanes |
| is_signed | input | 1 | Signedness for compare and right shift |
| cnt_from_reg | input | 1 | 1: shift count from src_b[4:0] |
| res | output | 32 | Registered result |
| res_valid | output | 1 | Result valid, one cycle after issue |

## Verification
The bench builds the unit with its default 32-bit word, which yields four byte lanes and two half-word lanes. With that width, random operands often hit lane-boundary carries, sign bits in every lane, and shift counts on both sides of 8 and 16 from both count sources. Directed vectors add the all-ones carry chain, counts exactly at the lane width, signed and unsigned readings of 0x80 against 0x7F, the reserved opcodes, holding while idle, and a reset in the middle of the run.

// File: rtl/psu_pkg.sv
package psu_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_CMPEQ = 3'd2,
        OP_CMPGT = 3'd3,
        OP_SHL   = 3'd4,
        OP_SHR   = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } psu_op_e;

    typedef enum logic {
        OUT_IDLE = 1'b0,
        OUT_LIVE = 1'b1
    } out_state_e;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
endpackage

// File: rtl/psu_addsub.sv
module psu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic              half,
    output logic [DATA_W-1:0] sum
);
    localparam int NB = DATA_W / 8;
    localparam int NP = NB / 2;

    logic [NP-1:0] pair_cy;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        logic [7:0] bx;
        assign bx = sub ? ~b[8*i +: 8] : b[8*i +: 8];
        if (i % 2 == 0) begin : g_low
            logic [8:0] t;
            assign t = {1'b0, a[8*i +: 8]} + {1'b0, bx} + {8'd0, sub};
            assign sum[8*i +: 8] = t[7:0];
            assign pair_cy[i/2]  = t[8];
        end else begin : g_high
            logic cin;
            assign cin = half ? pair_cy[i/2] : sub;
            assign sum[8*i +: 8] = a[8*i +: 8] + bx + {7'd0, cin};
        end
    end
endmodule

// File: rtl/psu_cmp.sv
module psu_cmp #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              gt_mode,
    input  logic              sgn,
    input  logic              half,
    output logic [DATA_W-1:0] mask
);
    localparam int NB = DATA_W / 8;
    localparam int NH = DATA_W / 16;

    logic [DATA_W-1:0] bmask;
    logic [DATA_W-1:0] hmask;

    for (genvar i = 0; i < NB; i++) begin : g_b
        logic [7:0] x, y;
        logic       hit;
        assign x = a[8*i +: 8];
        assign y = b[8*i +: 8];
        assign hit = gt_mode ? (sgn ? ($signed(x) > $signed(y)) : (x > y)) : (x == y);
        assign bmask[8*i +: 8] = {8{hit}};
    end

    for (genvar i = 0; i < NH; i++) begin : g_h
        logic [15:0] x, y;
        logic        hit;
        assign x = a[16*i +: 16];
        assign y = b[16*i +: 16];
        assign hit = gt_mode ? (sgn ? ($signed(x) > $signed(y)) : (x > y)) : (x == y);
        assign hmask[16*i +: 16] = {16{hit}};
    end

    assign mask = half ? hmask : bmask;
endmodule

// File: rtl/psu_shift.sv
module psu_shift #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic [DATA_W-1:0] a,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              right,
    input  logic              sgn,
    input  logic              half,
    output logic [DATA_W-1:0] out
);
    localparam int NB = DATA_W / 8;
    localparam int NH = DATA_W / 16;

    logic [DATA_W-1:0] bres;
    logic [DATA_W-1:0] hres;

    for (genvar i = 0; i < NB; i++) begin : g_b
        logic signed [8:0] ext, sr;
        logic [7:0]        sl;
        assign ext = {sgn & a[8*i+7], a[8*i +: 8]};
        assign sr  = ext >>> cnt;
        assign sl  = a[8*i +: 8] << cnt;
        assign bres[8*i +: 8] = right ? sr[7:0] : sl;
    end

    for (genvar i = 0; i < NH; i++) begin : g_h
        logic signed [16:0] ext, sr;
        logic [15:0]        sl;
        assign ext = {sgn & a[16*i+15], a[16*i +: 16]};
        assign sr  = ext >>> cnt;
        assign sl  = a[16*i +: 16] << cnt;
        assign hres[16*i +: 16] = right ? sr[15:0] : sl;
    end

    assign out = half ? hres : bres;
endmodule

// File: rtl/packed_subword_unit.sv
module packed_subword_unit #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [CNT_W-1:0]  shamt_imm,
    input  logic [2:0]        op,
    input  logic              lane_half,
    input  logic              is_signed,
    input  logic              cnt_from_reg,
    output logic [DATA_W-1:0] res,
    output logic              res_valid
);
    import psu_pkg::*;

    psu_op_e           op_e;
    out_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] as_out, cmp_out, sh_out, next_res;

    assign op_e = psu_op_e'(op);
    assign cnt  = cnt_from_reg ? src_b[CNT_W-1:0] : shamt_imm;

    psu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a(src_a), .b(src_b), .sub(op_e == OP_SUB), .half(lane_half), .sum(as_out)
    );

    psu_cmp #(.DATA_W(DATA_W)) u_cmp (
        .a(src_a), .b(src_b), .gt_mode(op_e == OP_CMPGT), .sgn(is_signed),
        .half(lane_half), .mask(cmp_out)
    );

    psu_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
        .a(src_a), .cnt(cnt), .right(op_e == OP_SHR), .sgn(is_signed),
        .half(lane_half), .out(sh_out)
    );

    always_comb begin
        unique case (op_e)
            OP_ADD, OP_SUB:     next_res = as_out;
            OP_CMPEQ, OP_CMPGT: next_res = cmp_out;
            OP_SHL, OP_SHR:     next_res = sh_out;
            default:            next_res = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            OUT_IDLE: state_d = in_valid ? OUT_LIVE : OUT_IDLE;
            OUT_LIVE: state_d = in_valid ? OUT_LIVE : OUT_IDLE;
            default:  state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= OUT_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)           res <= '0;
        else if (in_valid) res <= next_res;
    end

    assign res_valid = (state_q == OUT_LIVE);

    // R10
    issue_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid && $stable(res)));

    // R2
    byte_add_lane0_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd0 && !lane_half) |=>
        res[7:0] == 8'($past(src_a[7:0]) + $past(src_b[7:0])));

    // R4
    eq_mask_lane0_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd2 && !lane_half) |=>
        res[7:0] == (($past(src_a[7:0]) == $past(src_b[7:0])) ? 8'hFF : 8'h00));

    // R6
    shl_overrange_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd4 && !lane_half && !cnt_from_reg && shamt_imm >= 5'd8)
        |=> res == '0);

    // R9
    reserved_op_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[2:1] == 2'b11) |=> res == '0);
endmodule

// File: tb/packed_subword_unit_test.sv
`timescale 1ns/1ps
module packed_subword_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] src_a, src_b;
    logic [4:0]  shamt_imm;
    logic [2:0]  op;
    logic        lane_half, is_signed, cnt_from_reg;
    logic [31:0] res;
    logic        res_valid;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    packed_subword_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .shamt_imm(shamt_imm), .op(op), .lane_half(lane_half), .is_signed(is_signed),
        .cnt_from_reg(cnt_from_reg), .res(res), .res_valid(res_valid)
    );

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [4:0] imm, input logic [2:0] o,
                                          input logic hf, input logic sg, input logic fr);
        int w = hf ? 16 : 8;
        int n = 32 / w;
        longint m = (64'd1 << w) - 1;
        int sh = fr ? int'(b[4:0]) : int'(imm);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) begin
            longint la = (longint'(a) >> (i*w)) & m;
            longint lb = (longint'(b) >> (i*w)) & m;
            longint sa = la, sb = lb, v = 0;
            if (sg && la[w-1]) sa = la - (64'd1 << w);
            if (sg && lb[w-1]) sb = lb - (64'd1 << w);
            case (o)
                3'd0: v = (la + lb) & m;
                3'd1: v = (la - lb) & m;
                3'd2: v = (la == lb) ? m : 0;
                3'd3: v = (sa > sb) ? m : 0;
                3'd4: v = (la << sh) & m;
                3'd5: v = (sa >>> sh) & m;
                default: v = 0;
            endcase
            r = r | (32'(v) << (i*w));
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] o, input logic fr);
        case (o)
            3'd0: return "R2/R1";
            3'd1: return "R3/R1";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return fr ? "R8/R6" : "R6";
            3'd5: return fr ? "R8/R7" : "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_vec(input logic [31:0] a, input logic [31:0] b, input logic [4:0] imm,
                           input logic [2:0] o, input logic hf, input logic sg, input logic fr);
        logic [31:0] exp;
        @(negedge clk);
        src_a = a; src_b = b; shamt_imm = imm; op = o;
        lane_half = hf; is_signed = sg; cnt_from_reg = fr; in_valid = 1'b1;
        exp = model(a, b, imm, o, hf, sg, fr);
        @(negedge clk);
        in_valid = 1'b0;
        check(tag_of(o, fr), res, exp);
        check("R10 valid", {31'd0, res_valid}, 32'd1);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0; shamt_imm = '0;
        op = '0; lane_half = 1'b0; is_signed = 1'b0; cnt_from_reg = 1'b0;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 res", res, 32'd0);
        check("R12 valid", {31'd0, res_valid}, 32'd0);
        rst = 1'b0;

        // directed corner cases
        run_vec(32'h80FF7FFF, 32'h01010101, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0); // R2 carry cut bytes
        run_vec(32'h80FF7FFF, 32'h01010101, 5'd0, 3'd0, 1'b1, 1'b0, 1'b0); // R1 half carry
        run_vec(32'h00000000, 32'h01010101, 5'd0, 3'd1, 1'b0, 1'b1, 1'b0); // R3 borrow cut
        run_vec(32'h00010000, 32'h00000001, 5'd0, 3'd1, 1'b1, 1'b0, 1'b0); // R3 half
        run_vec(32'h12345678, 32'h12005678, 5'd0, 3'd2, 1'b0, 1'b0, 1'b0); // R4
        run_vec(32'h80807F7F, 32'h7F7F8080, 5'd0, 3'd3, 1'b0, 1'b1, 1'b0); // R5 signed
        run_vec(32'h80807F7F, 32'h7F7F8080, 5'd0, 3'd3, 1'b0, 1'b0, 1'b0); // R5 unsigned
        run_vec(32'h8000FFFF, 32'h7FFF0000, 5'd0, 3'd3, 1'b1, 1'b1, 1'b0); // R5 half
        run_vec(32'hFFFFFFFF, 32'h0, 5'd8,  3'd4, 1'b0, 1'b0, 1'b0); // R6 count = width
        run_vec(32'hFFFFFFFF, 32'h0, 5'd16, 3'd4, 1'b1, 1'b0, 1'b0); // R6 half
        run_vec(32'h80407F01, 32'h0, 5'd8,  3'd5, 1'b0, 1'b1, 1'b0); // R7 sign fill
        run_vec(32'h80407F01, 32'h0, 5'd8,  3'd5, 1'b0, 1'b0, 1'b0); // R7 logical
        run_vec(32'h8000F00F, 32'h0, 5'd3,  3'd5, 1'b1, 1'b1, 1'b0); // R7 half arith
        run_vec(32'h81818181, 32'hFFFFFFE3, 5'd1, 3'd4, 1'b0, 1'b0, 1'b1); // R8 reg count 3
        run_vec(32'h81818181, 32'h00000002, 5'd7, 3'd5, 1'b1, 1'b1, 1'b1); // R8 reg count 2
        run_vec(32'hDEADBEEF, 32'h12345678, 5'd2, 3'd6, 1'b0, 1'b0, 1'b0); // R9
        run_vec(32'hDEADBEEF, 32'h12345678, 5'd2, 3'd7, 1'b1, 1'b1, 1'b1); // R9

        // R11 hold while idle
        held = res;
        @(negedge clk);
        src_a = 32'hA5A5A5A5; src_b = 32'h5A5A5A5A; op = 3'd0;
        @(negedge clk);
        check("R11 res hold", res, held);
        check("R11 valid low", {31'd0, res_valid}, 32'd0);

        // random vectors
        for (int k = 0; k < 1500; k++) begin
            run_vec($urandom, $urandom, 5'($urandom), 3'($urandom_range(0, 7)),
                    1'($urandom), 1'($urandom), 1'($urandom));
        end

        // R12 mid-run reset
        run_vec(32'h11111111, 32'h22222222, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R12 res after reset", res, 32'd0);
        check("R12 valid after reset", {31'd0, res_valid}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule